// File: doc/BRIEF.md
# Auto-Refresh Scheduler with Deferred Refresh Credit

This block sits on the controller side of a DRAM memory controller and decides when auto-refresh commands go out. A free-running timer expires once every `refi_cycles` clock cycles. Each expiry adds one unit of refresh debt. Each issued refresh removes one. While debt is outstanding the block raises a request to the main command scheduler. When the scheduler grants it the command bus, the block runs a sequence: ask the bank controller to close every bank, wait until the banks have been idle for the precharge time, put one refresh command on the chip-select/row/column/write-enable pins, then hold off activates and further refreshes for the refresh cycle time.

A busy scheduler may withhold the grant and so defer refreshes. The debt saturates at eight. At that level the block raises an urgent flag, and the scheduler must honour it ahead of normal traffic. As a result, no two refreshes are ever more than nine intervals apart. Once granted, the block clears the debt with refreshes issued back to back, one refresh-cycle time apart, without another precharge, because a completed refresh leaves every bank closed. The memory supplies the refresh row itself, so this block drives no address.

Top module: `ref_sched`

## Requirements
- R1: Command pins {cs_n, ras_n, cas_n, we_n} carry 4'b0001 (refresh) in the single cycle a refresh is issued and 4'b0111 (no operation) in every other cycle after reset.
- R2: The interval timer expires once every `refi_cycles` cycles; with `ref_grant` and `banks_idle` held high, consecutive refreshes are exactly `refi_cycles` cycles apart.
- R3: `ref_req` is high whenever debt is nonzero or a sequence is in progress; a new sequence starts only while `ref_grant` is high, so no refresh is issued while the grant is withheld from an idle block.
- R4: `pre_all_req` is high from the start of a sequence until its refresh cycle; the refresh is issued only after `banks_idle` has been high for at least `T_RP` consecutive cycles, and `banks_idle` is high in the refresh cycle.
- R5: `act_block` is high in the refresh cycle and the `T_RFC-1` cycles after it, and no two refreshes are closer than `T_RFC` cycles.
- R6: With debt N>0 and the grant held, the block issues N refreshes; after the first, each follows the previous one by exactly `T_RFC` cycles; each refresh lowers the debt by one.
- R7: Debt saturates at `MAX_DEBT` (8); expiries at the cap are dropped, so a deferral of twelve intervals is paid back with exactly eight refreshes.
- R8: `ref_urgent` is high exactly while the debt equals `MAX_DEBT`; with a scheduler that grants on `ref_urgent`, the gap between refreshes never exceeds nine intervals.
- R9: During and after reset, with no expiry yet, the pins show no operation and `ref_req`, `ref_urgent`, `pre_all_req` and `act_block` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| refi_cycles | input | REFI_W | Average refresh interval in clock cycles |
| banks_idle | input | 1 | All banks precharged and closed |
| ref_grant | input | 1 | Scheduler hands the command bus to this block |
| ref_req | output | 1 | Refresh debt outstanding or sequence in progress |
| ref_urgent | output | 1 | Debt at the cap; the scheduler must grant |
| pre_all_req | output | 1 | Request to the bank controller to close all banks |
| act_block | output | 1 | Activates and refreshes forbidden (refresh cycle time) |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |

## Verification
The embedded properties check every cycle that the pins only ever show the two legal codes, that a refresh never goes out with the banks open, that the refresh window opens right after each refresh, that the debt stays at or below the cap and falls by one per refresh, and that the urgent flag drops only because of a refresh. Other behaviour only shows up over whole intervals, so the bench scenarios cover it: the exact spacing at steady state, the exact size of a repayment burst after a deferral, the dropped expiries at saturation, the stall while banks stay open, and the nine-interval bound under a scheduler that yields only to the urgent flag.

// File: rtl/ref_sched_pkg.sv
package ref_sched_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLOSE,
    ST_WAIT_RP,
    ST_ISSUE,
    ST_RFC
  } seq_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_REF = 4'b0001;

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int REFI_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REFI_W-1:0] refi_cycles,
  output logic              tick
);

  logic [REFI_W-1:0] cnt_q, cnt_d;
  logic [REFI_W:0]   cnt_inc;

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    tick    = (cnt_inc >= {1'b0, refi_cycles});
    cnt_d   = tick ? '0 : cnt_inc[REFI_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: expiries are isolated pulses when the interval exceeds one cycle
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && refi_cycles > 1 && $stable(refi_cycles)) |=> !tick);

endmodule

// File: rtl/ref_debt_ctr.sv
module ref_debt_ctr #(
  parameter int MAX_DEBT = 8,
  localparam int DW = $clog2(MAX_DEBT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ref_done,
  output logic [DW-1:0] debt,
  output logic          pending,
  output logic          urgent
);

  localparam logic [DW-1:0] DEBT_CAP = DW'(MAX_DEBT);

  logic [DW-1:0] debt_q, debt_d;
  logic          debt_en;

  always_comb begin
    debt_d  = debt_q;
    debt_en = 1'b0;
    unique case ({tick, ref_done})
      2'b10: begin
        debt_en = (debt_q != DEBT_CAP);
        debt_d  = debt_q + 1'b1;
      end
      2'b01: begin
        debt_en = (debt_q != '0);
        debt_d  = debt_q - 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       debt_q <= '0;
    else if (debt_en) debt_q <= debt_d;
  end

  assign debt    = debt_q;
  assign pending = (debt_q != '0);
  assign urgent  = (debt_q == DEBT_CAP);

  // R7: the debt never passes the cap
  assert_debt_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    debt_q <= DEBT_CAP);

  // R6: a refresh without a coincident expiry pays off exactly one unit
  assert_debt_paydown_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_done && !tick) |=> (debt_q == $past(debt_q) - DW'(1)));

  // R8: urgency ends only through an issued refresh
  assert_urgent_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(urgent) |-> $past(ref_done));

endmodule

// File: rtl/ref_seq_fsm.sv
module ref_seq_fsm
  import ref_sched_pkg::*;
#(
  parameter int T_RP  = 4,
  parameter int T_RFC = 12,
  localparam int CNT_MAX = (T_RP > T_RFC) ? T_RP : T_RFC,
  localparam int CW = $clog2(CNT_MAX + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pending,
  input  logic       grant,
  input  logic       banks_idle,
  output logic       pre_all_req,
  output logic       act_block,
  output logic       busy,
  output logic       ref_fire,
  output logic [3:0] cmd
);

  localparam logic [CW-1:0] RP_LAST  = CW'(T_RP - 1);
  localparam logic [CW-1:0] RFC_LAST = CW'(T_RFC - 2);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (pending && grant) state_d = ST_CLOSE;
      end
      ST_CLOSE: begin
        if (banks_idle) begin
          state_d = ST_WAIT_RP;
          cnt_d   = '0;
        end
      end
      ST_WAIT_RP: begin
        if (!banks_idle)            state_d = ST_CLOSE;
        else if (cnt_q == RP_LAST)  state_d = ST_ISSUE;
        else                        cnt_d   = cnt_q + 1'b1;
      end
      ST_ISSUE: begin
        state_d = ST_RFC;
        cnt_d   = '0;
      end
      ST_RFC: begin
        if (cnt_q == RFC_LAST) begin
          if (pending && grant) state_d = banks_idle ? ST_ISSUE : ST_CLOSE;
          else                  state_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign ref_fire    = (state_q == ST_ISSUE);
  assign pre_all_req = (state_q == ST_CLOSE) || (state_q == ST_WAIT_RP);
  assign act_block   = (state_q == ST_ISSUE) || (state_q == ST_RFC);
  assign busy        = (state_q != ST_IDLE);
  assign cmd         = ref_fire ? CMD_REF : CMD_NOP;

  // R4: refresh only with every bank closed
  assert_ref_banks_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ref_fire |-> banks_idle);

  // R5: the refresh window opens right after the refresh
  assert_rfc_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ref_fire |=> (act_block && !ref_fire));

  // R3: a sequence begins only under a grant
  assert_start_granted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(grant));

endmodule

// File: rtl/ref_sched.sv
module ref_sched
  import ref_sched_pkg::*;
#(
  parameter int REFI_W   = 16,
  parameter int T_RP     = 4,
  parameter int T_RFC    = 12,
  parameter int MAX_DEBT = 8,
  localparam int DW = $clog2(MAX_DEBT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REFI_W-1:0] refi_cycles,
  input  logic              banks_idle,
  input  logic              ref_grant,
  output logic              ref_req,
  output logic              ref_urgent,
  output logic              pre_all_req,
  output logic              act_block,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n
);

  logic [1:0]    rst_sync_q;
  logic          rst_i;
  logic          tick;
  logic          ref_fire;
  logic          pending;
  logic          busy;
  logic [DW-1:0] debt;
  logic [3:0]    cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  ref_interval_timer #(.REFI_W(REFI_W)) timer_i (
    .clk         (clk),
    .rst_n       (rst_i),
    .refi_cycles (refi_cycles),
    .tick        (tick)
  );

  ref_debt_ctr #(.MAX_DEBT(MAX_DEBT)) debt_i (
    .clk      (clk),
    .rst_n    (rst_i),
    .tick     (tick),
    .ref_done (ref_fire),
    .debt     (debt),
    .pending  (pending),
    .urgent   (ref_urgent)
  );

  ref_seq_fsm #(.T_RP(T_RP), .T_RFC(T_RFC)) seq_i (
    .clk         (clk),
    .rst_n       (rst_i),
    .pending     (pending),
    .grant       (ref_grant),
    .banks_idle  (banks_idle),
    .pre_all_req (pre_all_req),
    .act_block   (act_block),
    .busy        (busy),
    .ref_fire    (ref_fire),
    .cmd         (cmd)
  );

  assign ref_req = pending || busy;
  assign {cs_n, ras_n, cas_n, we_n} = cmd;

  // R1: only the two legal pin codes ever appear
  assert_cmd_legal_R1: assert property (@(posedge clk) disable iff (!rst_i)
    (!cs_n && we_n && (ras_n == cas_n)));

  // R8: urgency always comes with a request
  assert_urgent_req_R8: assert property (@(posedge clk) disable iff (!rst_i)
    ref_urgent |-> ref_req);

  // R8: urgency implies debt at the cap
  assert_urgent_cap_R8: assert property (@(posedge clk) disable iff (!rst_i)
    ref_urgent |-> (debt == DW'(MAX_DEBT)));

endmodule

// File: tb/ref_sched_tb_top.sv
module ref_sched_tb_top;

  localparam int REFI_W = 16;
  localparam int T_RP   = 4;
  localparam int T_RFC  = 12;
  localparam int REFI   = 200;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [REFI_W-1:0] refi_cycles;
  logic              banks_idle;
  logic              grant_man;
  logic              auto_mode;
  logic              sched_busy;
  logic              ref_grant;
  logic              ref_req, ref_urgent, pre_all_req, act_block;
  logic              cs_n, ras_n, cas_n, we_n;

  always #2 clk = ~clk;

  assign ref_grant = auto_mode ? (!sched_busy || ref_urgent) : grant_man;

  ref_sched #(.REFI_W(REFI_W), .T_RP(T_RP), .T_RFC(T_RFC), .MAX_DEBT(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .refi_cycles(refi_cycles), .banks_idle(banks_idle),
    .ref_grant(ref_grant), .ref_req(ref_req), .ref_urgent(ref_urgent),
    .pre_all_req(pre_all_req), .act_block(act_block),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  int    ref_count = 0;
  int    last_ref  = 0;
  bit    have_last = 0;
  int    blk_left  = 0;
  int    idle_run  = 0;
  bit    track_gap = 0;
  int    max_gap   = 0;
  int    exp_gap_q[$];
  string exp_tag_q[$];

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push_gap(int g, string tag);
    exp_gap_q.push_back(g);
    exp_tag_q.push_back(tag);
  endtask

  task automatic wait_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_refs(int n);
    int start;
    start = ref_count;
    while (ref_count < start + n) @(negedge clk);
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor and scoreboard: pops expected spacing as refreshes appear
  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] pins;
      int         gap;
      pins = {cs_n, ras_n, cas_n, we_n};
      gap  = 0;
      if (pins == 4'b0001) begin
        check(idle_run >= T_RP && banks_idle, "R4 idle-before-ref", idle_run, T_RP);
        if (have_last) begin
          gap = cyc - last_ref;
          check(gap >= T_RFC, "R5 min spacing", gap, T_RFC);
          if (track_gap && gap > max_gap) max_gap = gap;
        end
        if (exp_gap_q.size() > 0) begin
          int    e;
          string t;
          e = exp_gap_q.pop_front();
          t = exp_tag_q.pop_front();
          if (e != 0) check(have_last && gap == e, t, gap, e);
        end
        last_ref  = cyc;
        have_last = 1'b1;
        ref_count++;
        blk_left  = T_RFC;
      end else if (pins != 4'b0111) begin
        check(1'b0, "R1 pin code", int'(pins), 7);
      end
      if (blk_left > 0) begin
        if (!act_block) check(1'b0, "R5 act_block", 0, 1);
        blk_left--;
      end
      idle_run = banks_idle ? idle_run + 1 : 0;
    end
  end

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    int t0, base;
    rst_n       = 1'b0;
    refi_cycles = REFI_W'(REFI);
    banks_idle  = 1'b1;
    grant_man   = 1'b0;
    auto_mode   = 1'b0;
    sched_busy  = 1'b0;
    wait_cycles(5);

    // R9: reset state
    check({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R9 pins in reset", int'({cs_n, ras_n, cas_n, we_n}), 7);
    check(!ref_req && !ref_urgent, "R9 req/urgent in reset", int'({ref_req, ref_urgent}), 0);
    check(!pre_all_req && !act_block, "R9 pre/act in reset", int'({pre_all_req, act_block}), 0);
    rst_n = 1'b1;
    wait_cycles(10);
    check(!ref_req, "R9 no request before expiry", int'(ref_req), 0);
    check({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R9 nop after reset", int'({cs_n, ras_n, cas_n, we_n}), 7);

    // R2: steady spacing with grant and idle banks
    grant_man = 1'b1;
    wait_refs(1);
    for (int i = 0; i < 3; i++) push_gap(REFI, "R2 steady spacing");
    wait_refs(3);

    // R3 / R6: defer three intervals, then repay back to back
    grant_man = 1'b0;
    t0 = cyc;
    base = ref_count;
    while (cyc < t0 + 3 * REFI) @(negedge clk);
    check(ref_count == base, "R3 no refresh without grant", ref_count - base, 0);
    check(ref_req, "R3 request while debt owed", int'(ref_req), 1);
    push_gap(0, "R6");
    push_gap(T_RFC, "R6 burst spacing");
    push_gap(T_RFC, "R6 burst spacing");
    grant_man = 1'b1;
    wait_cycles(100);
    check(ref_count - base == 3, "R6 burst size", ref_count - base, 3);

    // R7 / R8: defer twelve intervals, saturate at eight
    wait_refs(1);
    grant_man = 1'b0;
    t0 = cyc;
    base = ref_count;
    while (cyc < t0 + 7 * REFI + REFI / 2) @(negedge clk);
    check(!ref_urgent, "R8 urgent low at debt 7", int'(ref_urgent), 0);
    while (cyc < t0 + 8 * REFI + REFI / 2) @(negedge clk);
    check(ref_urgent, "R8 urgent high at debt 8", int'(ref_urgent), 1);
    while (cyc < t0 + 12 * REFI) @(negedge clk);
    check(ref_urgent, "R7 held at cap", int'(ref_urgent), 1);
    push_gap(0, "R7");
    for (int i = 0; i < 7; i++) push_gap(T_RFC, "R7 repay spacing");
    grant_man = 1'b1;
    wait_cycles(150);
    check(ref_count - base == 8, "R7 saturated repay count", ref_count - base, 8);
    check(!ref_urgent && !ref_req, "R8 cleared after repay", int'({ref_urgent, ref_req}), 0);

    // R4: banks held open stalls the refresh
    wait_refs(1);
    banks_idle = 1'b0;
    base = ref_count;
    wait_cycles(REFI + 20);
    check(pre_all_req, "R4 close request while banks open", int'(pre_all_req), 1);
    check(ref_count == base, "R4 no refresh with banks open", ref_count - base, 0);
    t0 = cyc;
    banks_idle = 1'b1;
    wait_refs(1);
    check(last_ref - t0 >= T_RP, "R4 wait after close", last_ref - t0, T_RP);
    wait_cycles(1);
    check(!pre_all_req, "R4 close request dropped", int'(pre_all_req), 0);

    // R8: busy scheduler yields only on urgency
    wait_refs(1);
    sched_busy = 1'b1;
    auto_mode  = 1'b1;
    base       = ref_count;
    track_gap  = 1'b1;
    max_gap    = 0;
    wait_cycles(25 * REFI);
    track_gap = 1'b0;
    check(max_gap <= 9 * REFI && max_gap > 0, "R8 nine-interval bound", max_gap, 9 * REFI);
    check(ref_count - base >= 15, "R8 refreshes continue", ref_count - base, 15);
    check(exp_gap_q.size() == 0, "R6 scoreboard drained", exp_gap_q.size(), 0);

    finish_run();
  end

endmodule